// File: doc/BRIEF.md
# Quad Steering Multiplexer Latch

This block stores four independent bits, called lanes. Each lane has two data sources, a primary input and an alternate input. A shared two-bit select code chooses what reaches storage. The code can pass the primary input, pass the alternate input, pass the OR of both, or force a zero. Two active-low gate inputs control storage. While both gates are low the storage is transparent, so each output follows its steered input with no clock involved. When either gate rises, every lane keeps the value it had just before that edge.

An active-high clear input works asynchronously. It has priority over everything else and drives every stored bit to zero, in the transparent state and in the holding state. Each lane drives a true output and an inverted output. Applications that only need a one-bit choice can tie both select lines together. Code 00 then takes the primary input and code 11 takes the alternate input.

Top module: `quad_steer_latch`

## Requirements
- R1: The four lanes are independent. Output bit i depends only on the primary and alternate input bits i, the shared select code, the gates and the clear.
- R2: While clear is low and both gates (`gate_a_n`, `gate_b_n`) are low, the outputs follow changes of the steered value with no clock edge.
- R3: While either gate is high, the outputs keep the value present before that gate rose, whatever the data and select inputs do.
- R4: In the transparent state, select code {sel[1],sel[0]} = 00 passes the primary input (`prim_i`) to the output.
- R5: In the transparent state, select code 10 drives the output with the bitwise OR of the primary and alternate inputs.
- R6: In the transparent state, select code 01 drives every output to 0, whatever the data.
- R7: In the transparent state, select code 11 passes the alternate input (`alt_i`) to the output.
- R8: While clear (`clr`) is high, all true outputs are 0, in both the transparent and the holding state.
- R9: The inverted output (`q_n_o`) is the bitwise inverse of the true output (`q_o`) at all times.
- R10: If clear is released while a gate is high, the outputs stay 0 until the storage becomes transparent again.
- R11: When both select lines carry the same value, the block acts as a plain two-way choice: 0 takes the primary input and 1 takes the alternate input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| prim_i | input | 4 | Primary data source, one bit per lane |
| alt_i | input | 4 | Alternate data source, one bit per lane |
| sel | input | 2 | Steering code {sel[1],sel[0]} |
| gate_a_n | input | 1 | First active-low gate |
| gate_b_n | input | 1 | Second active-low gate |
| clr | input | 1 | Asynchronous active-high clear |
| q_o | output | 4 | True stored outputs |
| q_n_o | output | 4 | Inverted stored outputs |

## Verification
No register lies between any input and either output. Every result is therefore due in the same clock period as its stimulus, zero cycles later. The free-running bench clock serves only to pace the stimulus. The bench changes inputs just after a rising edge and samples at the following falling edge, so each output has half a period to settle before it is compared. In hold tests the bench first raises a gate and only then changes the data and select inputs, each change in a separate period. This lets a late capture show up as a wrong held value.

// File: rtl/qsl_pkg.sv
package qsl_pkg;

    localparam int LANES  = 4;
    localparam int SEL_W  = 2;

    typedef enum logic [SEL_W-1:0] {
        STEER_PRIM = 2'b00,
        STEER_ZERO = 2'b01,
        STEER_OR   = 2'b10,
        STEER_ALT  = 2'b11
    } steer_e;

    typedef struct packed {
        logic prim;
        logic alt;
    } lane_src_t;

    function automatic logic steer_bit(input steer_e mode, input lane_src_t src);
        logic r;
        case (mode)
            STEER_PRIM: r = src.prim;
            STEER_ZERO: r = 1'b0;
            STEER_OR:   r = src.prim | src.alt;
            default:    r = src.alt;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/qsl_steer.sv
module qsl_steer
    import qsl_pkg::*;
#(
    parameter int N = LANES
) (
    input  logic [N-1:0]     prim_i,
    input  logic [N-1:0]     alt_i,
    input  steer_e           mode_i,
    output logic [N-1:0]     steered_o
);
    for (genvar i = 0; i < N; i++) begin : g_lane
        lane_src_t src;
        assign src.prim = prim_i[i];
        assign src.alt  = alt_i[i];
        assign steered_o[i] = steer_bit(mode_i, src);
    end
endmodule

// File: rtl/qsl_gate.sv
module qsl_gate (
    input  logic gate_a_n,
    input  logic gate_b_n,
    output logic open_o
);
    assign open_o = ~gate_a_n & ~gate_b_n;
endmodule

// File: rtl/qsl_store.sv
module qsl_store #(
    parameter int N = qsl_pkg::LANES
) (
    input  logic         clr,
    input  logic         open_i,
    input  logic [N-1:0] next_i,
    output logic [N-1:0] state_o
);
    always_latch begin
        if (clr)
            state_o = '0;
        else if (open_i)
            state_o = next_i;
    end
endmodule

// File: rtl/quad_steer_latch.sv
module quad_steer_latch
    import qsl_pkg::*;
(
    input  logic [3:0] prim_i,
    input  logic [3:0] alt_i,
    input  logic [1:0] sel,
    input  logic       gate_a_n,
    input  logic       gate_b_n,
    input  logic       clr,
    output logic [3:0] q_o,
    output logic [3:0] q_n_o
);
    localparam int N = LANES;

    steer_e         mode;
    logic [N-1:0]   steered;
    logic           open;
    logic [N-1:0]   state;

    assign mode = steer_e'(sel);

    qsl_steer #(.N(N)) u_steer (
        .prim_i    (prim_i),
        .alt_i     (alt_i),
        .mode_i    (mode),
        .steered_o (steered)
    );

    qsl_gate u_gate (
        .gate_a_n (gate_a_n),
        .gate_b_n (gate_b_n),
        .open_o   (open)
    );

    qsl_store #(.N(N)) u_store (
        .clr     (clr),
        .open_i  (open),
        .next_i  (steered),
        .state_o (state)
    );

    assign q_o   = state;
    assign q_n_o = ~state;

    // Output checks against port-level stimulus
    always_comb begin
        if (clr) begin
            p_clear_zero_r8: assert (q_o == '0)
                else $error("clear active but outputs nonzero");
        end
        if (!clr && !gate_a_n && !gate_b_n) begin
            if (sel == 2'b00) begin
                p_pass_prim_r4: assert (q_o == prim_i)
                    else $error("code 00 not passing primary");
            end
            if (sel == 2'b01) begin
                p_force_low_r6: assert (q_o == '0)
                    else $error("code 01 not forcing zero");
            end
            if (sel == 2'b10) begin
                p_or_both_r5: assert (q_o == (prim_i | alt_i))
                    else $error("code 10 not OR of sources");
            end
            if (sel == 2'b11) begin
                p_pass_alt_r7: assert (q_o == alt_i)
                    else $error("code 11 not passing alternate");
            end
        end
    end
endmodule

// File: tb/test_quad_steer_latch.sv
module test_quad_steer_latch;
    logic       clk = 1'b0;
    logic [3:0] prim_i, alt_i;
    logic [1:0] sel;
    logic       gate_a_n, gate_b_n, clr;
    logic [3:0] q_o, q_n_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    quad_steer_latch i_quad_steer_latch (
        .prim_i   (prim_i),
        .alt_i    (alt_i),
        .sel      (sel),
        .gate_a_n (gate_a_n),
        .gate_b_n (gate_b_n),
        .clr      (clr),
        .q_o      (q_o),
        .q_n_o    (q_n_o)
    );

    function automatic logic [3:0] model(input logic [1:0] s, input logic [3:0] p, input logic [3:0] a);
        logic [3:0] r;
        for (int i = 0; i < 4; i++) begin
            case (s)
                2'b00: r[i] = p[i];
                2'b01: r[i] = 1'b0;
                2'b10: r[i] = p[i] | a[i];
                default: r[i] = a[i];
            endcase
        end
        return r;
    endfunction

    task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive(input logic [3:0] p, input logic [3:0] a, input logic [1:0] s,
                         input logic ga, input logic gb, input logic c);
        @(posedge clk);
        #1;
        prim_i = p; alt_i = a; sel = s; gate_a_n = ga; gate_b_n = gb; clr = c;
        @(negedge clk);
    endtask

    task automatic check_inv(input string req);
        check(req, q_n_o, ~q_o);
    endtask

    initial begin
        prim_i = '0; alt_i = '0; sel = '0; gate_a_n = 1'b0; gate_b_n = 1'b0; clr = 1'b1;
        // reset state
        drive(4'hF, 4'hF, 2'b11, 1'b0, 1'b0, 1'b1);
        check("R8 clear while transparent", q_o, 4'h0);
        check("R9 inverse after clear", q_n_o, 4'hF);

        // exhaustive sweep of codes and data: R1 R2 R4 R5 R6 R7 R9
        for (int s = 0; s < 4; s++) begin
            for (int p = 0; p < 16; p++) begin
                for (int a = 0; a < 16; a++) begin
                    drive(p[3:0], a[3:0], s[1:0], 1'b0, 1'b0, 1'b0);
                    case (s)
                        0: check("R4 code00 primary R1", q_o, model(2'b00, p[3:0], a[3:0]));
                        1: check("R6 code01 zero R1", q_o, model(2'b01, p[3:0], a[3:0]));
                        2: check("R5 code10 OR R1", q_o, model(2'b10, p[3:0], a[3:0]));
                        default: check("R7 code11 alternate R1", q_o, model(2'b11, p[3:0], a[3:0]));
                    endcase
                    check_inv("R9 inverse in sweep");
                end
            end
        end

        // R2: follows changes while transparent
        drive(4'h5, 4'h0, 2'b00, 1'b0, 1'b0, 1'b0);
        drive(4'hA, 4'h0, 2'b00, 1'b0, 1'b0, 1'b0);
        check("R2 follows primary change", q_o, 4'hA);

        // R11: tied select lines
        drive(4'h3, 4'hC, 2'b00, 1'b0, 1'b0, 1'b0);
        check("R11 tied low selects primary", q_o, 4'h3);
        drive(4'h3, 4'hC, 2'b11, 1'b0, 1'b0, 1'b0);
        check("R11 tied high selects alternate", q_o, 4'hC);

        // R3: hold with gate A, then with gate B, then both
        for (int g = 0; g < 3; g++) begin
            logic ga, gb;
            ga = (g != 1);
            gb = (g != 0);
            drive(4'h9, 4'h6, 2'b00, 1'b0, 1'b0, 1'b0);
            check("R4 setup before hold", q_o, 4'h9);
            drive(4'h9, 4'h6, 2'b00, ga, gb, 1'b0);
            check("R3 hold after gate rise", q_o, 4'h9);
            drive(4'h0, 4'h6, 2'b00, ga, gb, 1'b0);
            check("R3 hold ignores primary", q_o, 4'h9);
            drive(4'h0, 4'hF, 2'b11, ga, gb, 1'b0);
            check("R3 hold ignores select and alternate", q_o, 4'h9);
            drive(4'h0, 4'h0, 2'b01, ga, gb, 1'b0);
            check("R3 hold ignores force-zero code", q_o, 4'h9);
            check_inv("R9 inverse while holding");
            drive(4'h0, 4'h0, 2'b01, 1'b0, 1'b0, 1'b0);
            check("R2 reopen follows zero code", q_o, 4'h0);
        end

        // R8 and R10: clear during hold, release while holding
        drive(4'hE, 4'h0, 2'b00, 1'b0, 1'b0, 1'b0);
        drive(4'hE, 4'h0, 2'b00, 1'b1, 1'b0, 1'b0);
        check("R3 held before clear", q_o, 4'hE);
        drive(4'hE, 4'h0, 2'b00, 1'b1, 1'b0, 1'b1);
        check("R8 clear while holding", q_o, 4'h0);
        check("R9 inverse under clear", q_n_o, 4'hF);
        drive(4'hE, 4'h0, 2'b00, 1'b1, 1'b0, 1'b0);
        check("R10 released while holding stays zero", q_o, 4'h0);
        drive(4'hE, 4'h7, 2'b10, 1'b0, 1'b1, 1'b0);
        check("R10 still zero with other gate high", q_o, 4'h0);
        drive(4'hE, 4'h7, 2'b10, 1'b0, 1'b0, 1'b0);
        check("R10 reopen loads OR", q_o, 4'hF);
        drive(4'hE, 4'h7, 2'b10, 1'b0, 1'b0, 1'b1);
        check("R8 clear overrides transparent path", q_o, 4'h0);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule